// File: doc/BRIEF.md
# SDRAM Refresh Request Timer

This block paces auto-refresh for an SDRAM controller. A two-bit rate code picks one of three refresh intervals, or switches refresh off altogether. The memory clock is the CPU bus clock, which may run at one of a few frequencies. A two-bit frequency code names the frequency in use, and the block turns the chosen interval into a whole number of clock cycles for that clock.

Each time an interval ends, one refresh is owed. Owed refreshes are counted, so none is lost while the command arbiter is busy with other traffic. The request output stays high as long as at least one refresh is owed. The arbiter pulses the acknowledge input once for each refresh it issues. If the count of owed refreshes is already at its limit, further interval expiries are dropped and a sticky overflow flag records that this happened. Issuing the refresh command itself and sequencing the precharges are left to the controller.

Top module: `refresh_req_timer`

## Requirements
- R1: After reset, `refresh_req` and `overflow` are both 0.
- R2: While `rate_sel` is 2'b00, no interval expires and `refresh_req` stays 0, for any amount of time.
- R3: The interval length L in cycles is floor(MHz × tenths / 10). The frequency codes map to MHz as 2'b00 = 66, 2'b01 = 100, and both 2'b10 and 2'b11 = 133. The rate codes map to tenths of a microsecond as 2'b01 = 78, 2'b10 = 156 and 2'b11 = 1250.
- R4: With the rate and frequency codes held steady, interval expiries follow one another every L cycles.
- R5: Each expiry adds one to the owed count and each acknowledge cycle takes one away. An acknowledge while nothing is owed is ignored. `refresh_req` is high exactly while the owed count is nonzero, and it changes at the clock edge that updates the count.
- R6: A new nonzero rate code restarts the interval. The first expiry under the new code comes at the L-th clock edge after the edge that first samples that code, and `refresh_req` is high after that edge. Refreshes already owed are kept.
- R7: Any clock edge that samples rate code 2'b00 clears the owed count, so `refresh_req` is 0 after that edge.
- R8: The owed count saturates at 8. An expiry that arrives while 8 are owed, with no acknowledge in the same cycle, is dropped and sets `overflow`. `overflow` then stays 1 until reset, and rate code 2'b00 does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory interface clock (CPU bus clock) |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Refresh rate code; 2'b00 turns refresh off |
| freq_sel | input | 2 | Code for the bus clock frequency |
| refresh_ack | input | 1 | One cycle per refresh issued by the arbiter |
| refresh_req | output | 1 | High while at least one refresh is owed |
| overflow | output | 1 | Sticky flag: an expiry was dropped at saturation |

## Verification
After a new rate code is first sampled, `refresh_req` is due L+1 falling edges later. The bench counts falling edges from the one after the drive and compares that count with L, which it computes itself from the frequency and rate codes. Later expiries are due every L falling edges. An acknowledge or a switch to code 2'b00 shows at `refresh_req` on the next falling edge. Acknowledges are always placed well away from any expiry, so the owed count can be read exactly from the number of acknowledges it takes to drop the request.

// File: rtl/rfr_pkg.sv
package rfr_pkg;

  // Cycles in an interval, rounded down so the interval is never exceeded.
  function automatic int unsigned cycles_for(input int unsigned mhz,
                                             input int unsigned tenths_us);
    return (mhz * tenths_us) / 10;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rfr_interval_lut.sv
module rfr_interval_lut #(
  parameter int unsigned MHZ_0   = 66,
  parameter int unsigned MHZ_1   = 100,
  parameter int unsigned MHZ_2   = 133,
  parameter int unsigned TENTH_1 = 78,
  parameter int unsigned TENTH_2 = 156,
  parameter int unsigned TENTH_3 = 1250,
  parameter int unsigned CNT_W   = 15
) (
  input  logic [1:0]       rate_sel,
  input  logic [1:0]       freq_sel,
  output logic [CNT_W-1:0] limit
);

  logic [CNT_W-1:0] table_q [4][4];

  for (genvar f = 0; f < 4; f++) begin : g_freq
    localparam int unsigned FMHZ = (f == 0) ? MHZ_0 : (f == 1) ? MHZ_1 : MHZ_2;
    for (genvar r = 0; r < 4; r++) begin : g_rate
      localparam int unsigned TT = (r == 1) ? TENTH_1 :
                                   (r == 2) ? TENTH_2 :
                                   (r == 3) ? TENTH_3 : 0;
      assign table_q[f][r] = CNT_W'(rfr_pkg::cycles_for(FMHZ, TT));
    end
  end

  assign limit = table_q[freq_sel][rate_sel];

endmodule

// File: rtl/rfr_tick_gen.sv
module rfr_tick_gen #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       rate_sel,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [1:0]       rate_q;
  logic [CNT_W-1:0] cnt_q;
  logic             off;
  logic             change;

  assign off    = (rate_sel == 2'b00);
  assign change = (rate_sel != rate_q);
  assign expire = !off && !change && (cnt_q >= limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= 2'b00;
      cnt_q  <= '0;
    end else begin
      rate_q <= rate_sel;
      if (off || change || expire) cnt_q <= '0;
      else                         cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/rfr_pending.sv
module rfr_pending #(
  parameter int unsigned PEND_MAX = 8,
  localparam int unsigned PW = $clog2(PEND_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic expire,
  input  logic ack,
  output logic req,
  output logic ovf
);

  logic [PW-1:0] pend_q;
  logic [PW-1:0] pend_n;
  logic          full;
  logic          dec;
  logic          drop;

  assign full = (pend_q == PW'(PEND_MAX));
  assign dec  = ack && (pend_q != '0);
  assign drop = !clear && expire && full && !dec;

  always_comb begin
    pend_n = pend_q;
    if (clear) begin
      pend_n = '0;
    end else begin
      unique case ({expire, dec})
        2'b10:   if (!full) pend_n = pend_q + PW'(1);
        2'b01:   pend_n = pend_q - PW'(1);
        default: pend_n = pend_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      req    <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      pend_q <= pend_n;
      req    <= (pend_n != '0);
      ovf    <= ovf | drop;
    end
  end

endmodule

// File: rtl/refresh_req_timer.sv
module refresh_req_timer #(
  parameter int unsigned MHZ_0    = 66,
  parameter int unsigned MHZ_1    = 100,
  parameter int unsigned MHZ_2    = 133,
  parameter int unsigned TENTH_1  = 78,
  parameter int unsigned TENTH_2  = 156,
  parameter int unsigned TENTH_3  = 1250,
  parameter int unsigned PEND_MAX = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic [1:0] freq_sel,
  input  logic       refresh_ack,
  output logic       refresh_req,
  output logic       overflow
);

  localparam int unsigned MAX_CYC = rfr_pkg::cycles_for(
      rfr_pkg::max3(MHZ_0, MHZ_1, MHZ_2),
      rfr_pkg::max3(TENTH_1, TENTH_2, TENTH_3));
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] limit;
  logic             expire;
  logic             clear;

  assign clear = (rate_sel == 2'b00);

  rfr_interval_lut #(
    .MHZ_0(MHZ_0), .MHZ_1(MHZ_1), .MHZ_2(MHZ_2),
    .TENTH_1(TENTH_1), .TENTH_2(TENTH_2), .TENTH_3(TENTH_3),
    .CNT_W(CNT_W)
  ) u_lut (
    .rate_sel(rate_sel),
    .freq_sel(freq_sel),
    .limit(limit)
  );

  rfr_tick_gen #(.CNT_W(CNT_W)) u_tick (
    .clk(clk),
    .rst(rst),
    .rate_sel(rate_sel),
    .limit(limit),
    .expire(expire)
  );

  rfr_pending #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk),
    .rst(rst),
    .clear(clear),
    .expire(expire),
    .ack(refresh_ack),
    .req(refresh_req),
    .ovf(overflow)
  );

endmodule

// File: rtl/rfr_checker.sv
module rfr_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] rate_sel,
  input logic       refresh_ack,
  input logic       expire,
  input logic       refresh_req,
  input logic       overflow
);

  assert_off_no_expiry_R2: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == 2'b00) |-> !expire);

  assert_off_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == 2'b00) |=> !refresh_req);

  assert_rise_from_expiry_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(refresh_req) |-> $past(expire));

  assert_fall_from_ack_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(refresh_req) |-> $past(refresh_ack || (rate_sel == 2'b00)));

  assert_single_expiry_R4: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

endmodule

bind refresh_req_timer rfr_checker u_chk (
  .clk(clk),
  .rst(rst),
  .rate_sel(rate_sel),
  .refresh_ack(refresh_ack),
  .expire(expire),
  .refresh_req(refresh_req),
  .overflow(overflow)
);

// File: tb/tb_refresh_req_timer.sv
module tb_refresh_req_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rate_sel = 2'b00;
  logic [1:0] freq_sel = 2'b00;
  logic       refresh_ack = 1'b0;
  logic       refresh_req;
  logic       overflow;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  refresh_req_timer dut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .freq_sel(freq_sel),
    .refresh_ack(refresh_ack), .refresh_req(refresh_req), .overflow(overflow)
  );

  function automatic int exp_len(input int f, input int r);
    int mhz;
    int t;
    mhz = (f == 0) ? 66 : (f == 1) ? 100 : 133;
    t   = (r == 1) ? 78 : (r == 2) ? 156 : 1250;
    return (mhz * t) / 10;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count falling edges until refresh_req is seen high (-1 on timeout).
  task automatic wait_rise(output int n);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      n++;
      if (refresh_req) return;
    end
    n = -1;
  endtask

  task automatic ack_cycles(input int n);
    refresh_ack = 1'b1;
    idle(n);
    refresh_ack = 1'b0;
  endtask

  initial begin
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=<190000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int seen;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 req", refresh_req, 0);
    check("R1 ovf", overflow, 0);

    // R3 sweep of every frequency code with every nonzero rate code
    for (int f = 0; f < 4; f++) begin
      for (int r = 1; r < 4; r++) begin
        rate_sel = 2'b00;
        @(negedge clk);
        freq_sel = 2'(f);
        rate_sel = 2'(r);
        wait_rise(n);
        check($sformatf("R3 f=%0d r=%0d first expiry", f, r), n, exp_len(f, r) + 1);
      end
    end

    // R4/R5 periodicity and owed count, f=100MHz, 7.8us
    rate_sel = 2'b00;
    @(negedge clk);
    freq_sel = 2'b01;
    rate_sel = 2'b01;
    wait_rise(n);
    check("R6 first after restart", n, 781);
    refresh_ack = 1'b1;
    @(negedge clk);
    refresh_ack = 1'b0;
    check("R5 ack drops req", refresh_req, 0);
    n = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      n++;
      if (refresh_req) break;
    end
    check("R4 period", n, 780);
    idle(1570);                      // two more expiries: 3 owed
    ack_cycles(2);
    check("R5 one still owed", refresh_req, 1);
    ack_cycles(1);
    check("R5 all acknowledged", refresh_req, 0);
    ack_cycles(5);                   // acknowledges with nothing owed
    check("R5 ack at zero keeps req low", refresh_req, 0);
    wait_rise(n);
    idle(3);
    check("R5 ack at zero did not wrap count", refresh_req, 1);
    ack_cycles(1);
    check("R5 single owed cleared", refresh_req, 0);

    // R6 mid-interval change of rate code
    idle(100);
    rate_sel = 2'b10;
    wait_rise(n);
    check("R6 restart on change", n, 1561);

    // R7 switching off clears owed refreshes
    rate_sel = 2'b00;
    @(negedge clk);
    check("R7 cleared after off", refresh_req, 0);

    // R8 saturation at 8 owed, 66MHz, 7.8us (L=514)
    freq_sel = 2'b00;
    rate_sel = 2'b01;
    idle(8 * 514 + 6);
    check("R8 eight owed no ovf", overflow, 0);
    idle(514);
    check("R8 ninth expiry sets ovf", overflow, 1);
    ack_cycles(7);
    check("R8 one left after seven acks", refresh_req, 1);
    ack_cycles(1);
    check("R8 ninth was dropped", refresh_req, 0);
    rate_sel = 2'b00;
    @(negedge clk);
    check("R8 ovf survives off code", overflow, 1);

    // R2 long hold at code 00
    seen = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (refresh_req) seen++;
    end
    check("R2 no requests while off", seen, 0);

    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ovf after reset", overflow, 0);
    check("R1 req after reset", refresh_req, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule